// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-cycle processor and computes the next address on every clock edge. The current value drives the instruction memory address. An incremented copy (current address plus four) goes out for use elsewhere, for example as a link value. Decode and the register comparison happen outside the block. The block only receives a branch request, the ALU zero flag, a jump request and the two immediate fields of the current instruction.

Three candidate addresses are formed in parallel. The first is the sequential address. The second is a PC-relative branch target: the 16-bit offset is sign-extended, scaled to words and added to the sequential address. The third is a pseudo-absolute jump target: it keeps the top bits of the sequential address and fills the rest with the 26-bit field scaled to words. A fixed priority picks one of them, and the chosen address is loaded into the register at the next edge. A synchronous reset returns the counter to address zero.

Top module: `pc_sequencer`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc_o` becomes 0x00000000 after that edge, whatever the request inputs are.
- R2: With `jmp_req` low and the branch not taken (`br_req` low), `pc_o` advances by 4 at each edge. `alu_zero` alone has no effect.
- R3: With `jmp_req` low and both `br_req` and `alu_zero` high, the next `pc_o` equals `pc_o + 4 + (sign_extend(imm_off) << 2)`, computed modulo 2^32.
- R4: With `br_req` high but `alu_zero` low, the branch is not taken and `pc_o` advances by 4.
- R5: `jmp_req` high takes priority over a taken branch. A taken branch takes priority over the sequential step.
- R6: A negative offset gives a backward target. `imm_off` = 0xFFFF with a taken branch leaves `pc_o` unchanged (PC+4-4).
- R7: `pc_plus4_o` always equals `pc_o + 4` in the same cycle.
- R8: Outside reset, bits [1:0] of `pc_o` are always 00.
- R9: The jump target is `{pc_plus4[31:28], jmp_field, 2'b00}`. Its top four bits come from PC+4, so a jump taken at 0x0FFFFFFC lands in the 0x1xxxxxxx region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_req | input | 1 | Current instruction is a conditional branch |
| alu_zero | input | 1 | ALU result was zero (compared operands equal) |
| jmp_req | input | 1 | Current instruction is an unconditional jump |
| imm_off | input | 16 | Signed branch offset, counted in words |
| jmp_field | input | 26 | Word index of the jump target within its region |
| pc_o | output | 32 | Current program counter (instruction address) |
| pc_plus4_o | output | 32 | Current program counter plus four |

## Verification
The only state in this block is the counter register. Any wrong selection or wrong target arithmetic therefore shows up on `pc_o` one edge after the cycle that caused it. The error then stays, because every later address is built from the corrupted value. The bench keeps its own model of the counter and compares `pc_o` and `pc_plus4_o` a quarter period after each edge. A fault is seen in the same cycle it appears, and a priority mix-up is exposed by driving branch and jump requests together.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam int unsigned DEF_PC_W  = 32;
  localparam int unsigned DEF_IMM_W = 16;
  localparam int unsigned DEF_JF_W  = 26;

  // one-hot source select for the next program counter
  typedef enum logic [2:0] {
    SEL_SEQ = 3'b001,
    SEL_BR  = 3'b010,
    SEL_JMP = 3'b100
  } nxt_sel_e;

endpackage

// File: rtl/pcseq_incr.sv
module pcseq_incr #(
  parameter int unsigned PC_W = pcseq_pkg::DEF_PC_W,
  parameter int unsigned STEP = 4
) (
  input  logic [PC_W-1:0] pc_cur,
  output logic [PC_W-1:0] pc_seq
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  function automatic logic [PC_W-1:0] f_step(input logic [PC_W-1:0] a);
    return a + STEP_V;
  endfunction

  assign pc_seq = f_step(pc_cur);

endmodule

// File: rtl/pcseq_target_gen.sv
module pcseq_target_gen #(
  parameter int unsigned PC_W  = pcseq_pkg::DEF_PC_W,
  parameter int unsigned IMM_W = pcseq_pkg::DEF_IMM_W,
  parameter int unsigned JF_W  = pcseq_pkg::DEF_JF_W
) (
  input  logic [PC_W-1:0]  pc_plus4,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [JF_W-1:0]  jmp_field,
  output logic [PC_W-1:0]  br_offset,
  output logic [PC_W-1:0]  br_target,
  output logic [PC_W-1:0]  jmp_target
);

  localparam int EXT_W  = PC_W - IMM_W - 2;
  localparam int KEEP_W = PC_W - JF_W - 2;

  // sign-extend a word offset and scale it to bytes
  function automatic logic [PC_W-1:0] f_word_offset(input logic [IMM_W-1:0] imm);
    return {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  endfunction

  function automatic logic [PC_W-1:0] f_rel_target(input logic [PC_W-1:0] base,
                                                  input logic [PC_W-1:0] ofs);
    return base + ofs;
  endfunction

  assign br_offset = f_word_offset(imm_off);
  assign br_target = f_rel_target(pc_plus4, br_offset);

  // region bits are kept only when the field does not fill the whole word
  generate
    if (KEEP_W > 0) begin : g_region
      assign jmp_target = {pc_plus4[PC_W-1 -: KEEP_W], jmp_field, 2'b00};
    end else begin : g_flat
      assign jmp_target = PC_W'({jmp_field, 2'b00});
    end
  endgenerate

endmodule

// File: rtl/pcseq_next_sel.sv
module pcseq_next_sel #(
  parameter int unsigned PC_W = pcseq_pkg::DEF_PC_W
) (
  input  logic                jmp_req,
  input  logic                br_req,
  input  logic                alu_zero,
  input  logic [PC_W-1:0]     seq_addr,
  input  logic [PC_W-1:0]     br_addr,
  input  logic [PC_W-1:0]     jmp_addr,
  output pcseq_pkg::nxt_sel_e sel,
  output logic                br_taken,
  output logic [PC_W-1:0]     next_pc
);
  import pcseq_pkg::*;

  assign br_taken = br_req & alu_zero;

  // fixed priority: jump, then taken branch, then sequential
  always_comb begin
    if (jmp_req)       sel = SEL_JMP;
    else if (br_taken) sel = SEL_BR;
    else               sel = SEL_SEQ;
  end

  always_comb begin
    unique case (sel)
      SEL_JMP: next_pc = jmp_addr;
      SEL_BR:  next_pc = br_addr;
      default: next_pc = seq_addr;
    endcase
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int unsigned PC_W     = pcseq_pkg::DEF_PC_W,
  parameter int unsigned IMM_W    = pcseq_pkg::DEF_IMM_W,
  parameter int unsigned JF_W     = pcseq_pkg::DEF_JF_W,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_req,
  input  logic             alu_zero,
  input  logic             jmp_req,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [JF_W-1:0]  jmp_field,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  pc_plus4_o
);
  import pcseq_pkg::*;

  localparam logic [PC_W-1:0] RST_V = PC_W'(RESET_PC);
  localparam int KEEP_W = PC_W - JF_W - 2;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_plus4;
  logic [PC_W-1:0] br_offset;
  logic [PC_W-1:0] br_target;
  logic [PC_W-1:0] jmp_target;
  logic [PC_W-1:0] next_pc;
  logic            br_taken;
  nxt_sel_e        sel;

  pcseq_incr #(.PC_W(PC_W), .STEP(4)) u_incr (
    .pc_cur (pc_q),
    .pc_seq (pc_plus4)
  );

  pcseq_target_gen #(.PC_W(PC_W), .IMM_W(IMM_W), .JF_W(JF_W)) u_tgt (
    .pc_plus4   (pc_plus4),
    .imm_off    (imm_off),
    .jmp_field  (jmp_field),
    .br_offset  (br_offset),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  pcseq_next_sel #(.PC_W(PC_W)) u_sel (
    .jmp_req  (jmp_req),
    .br_req   (br_req),
    .alu_zero (alu_zero),
    .seq_addr (pc_plus4),
    .br_addr  (br_target),
    .jmp_addr (jmp_target),
    .sel      (sel),
    .br_taken (br_taken),
    .next_pc  (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RST_V;
    else     pc_q <= next_pc;
  end

  assign pc_o       = pc_q;
  assign pc_plus4_o = pc_plus4;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc_q == RST_V)); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!jmp_req && !(br_req && alu_zero)) |=> (pc_q == $past(pc_q) + PC_W'(4))); // R2

  AST_BRANCH_TAKE: assert property (@(posedge clk) disable iff (rst)
    (!jmp_req && br_taken) |=> (pc_q == $past(pc_plus4) + $past(br_offset))); // R3

  AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!jmp_req && br_req && !alu_zero) |=> (pc_q == $past(pc_plus4))); // R4

  AST_JUMP_WINS: assert property (@(posedge clk) disable iff (rst)
    jmp_req |=> (pc_q[JF_W+1:0] == {$past(jmp_field), 2'b00})); // R5

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    jmp_req |=> (pc_q[PC_W-1 -: KEEP_W] == $past(pc_plus4[PC_W-1 -: KEEP_W]))); // R9

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1); // R5

  AST_INCR_REL: assert property (@(posedge clk) disable iff (rst)
    (pc_plus4 - pc_q) == PC_W'(4)); // R7

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00); // R8

endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_req = 1'b0;
  logic        alu_zero = 1'b0;
  logic        jmp_req = 1'b0;
  logic [15:0] imm_off = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] pc_o;
  logic [31:0] pc_plus4_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] model_pc = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  pc_sequencer u_dut (
    .clk        (clk),
    .rst        (rst),
    .br_req     (br_req),
    .alu_zero   (alu_zero),
    .jmp_req    (jmp_req),
    .imm_off    (imm_off),
    .jmp_field  (jmp_field),
    .pc_o       (pc_o),
    .pc_plus4_o (pc_plus4_o)
  );

  // driver: one instruction per cycle, expected next PC pushed to the scoreboard
  task automatic step(input logic br, input logic z, input logic j,
                      input logic [15:0] imm, input logic [25:0] jf, input string tag);
    logic [31:0] seq;
    logic [31:0] nxt;
    @(negedge clk);
    rst = 1'b0; br_req = br; alu_zero = z; jmp_req = j;
    imm_off = imm; jmp_field = jf;
    seq = model_pc + 32'd4;
    if (j)           nxt = (seq & 32'hF000_0000) | (32'(jf) * 32'd4);
    else if (br && z) nxt = seq + 32'($signed(imm)) * 32'd4;
    else             nxt = seq;
    model_pc = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; jmp_req = 1'b1; br_req = 1'b1; alu_zero = 1'b1;
    jmp_field = 26'h155_5555; imm_off = 16'h0040;
    model_pc = '0;
    exp_q.push_back(32'h0);
    tag_q.push_back(tag);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc_o !== e) begin
        errors++;
        $display("FAIL %s pc_o actual=%h expected=%h", t, pc_o, e);
      end
      checks++;
      if (pc_plus4_o !== e + 32'd4) begin
        errors++;
        $display("FAIL R7 pc_plus4_o actual=%h expected=%h", pc_plus4_o, e + 32'd4);
      end
      checks++;
      if (pc_o[1:0] !== 2'b00) begin
        errors++;
        $display("FAIL R8 pc_o low bits actual=%b expected=00", pc_o[1:0]);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset("R1 reset with requests high");
    step(0, 0, 0, 16'h0000, 26'h0, "R2 sequential 1");
    step(0, 0, 0, 16'h1234, 26'h3, "R2 sequential 2");
    step(0, 0, 0, 16'h0000, 26'h0, "R2 sequential 3");
    step(1, 0, 0, 16'h0010, 26'h0, "R4 branch not taken");
    step(1, 1, 0, 16'h0003, 26'h0, "R3 branch taken forward");
    step(0, 1, 0, 16'h0020, 26'h0, "R2 zero without branch ignored");
    step(1, 1, 0, 16'hFFFF, 26'h0, "R6 offset -1 stays");
    step(1, 1, 0, 16'hFFF8, 26'h0, "R6 offset -8 backward");
    step(1, 1, 1, 16'h0100, 26'h100, "R5 jump beats branch");
    step(0, 0, 1, 16'h0000, 26'h3FF_FFFF, "R5 jump to region top");
    step(0, 0, 1, 16'h0000, 26'h10, "R9 region from PC+4");
    step(1, 1, 0, 16'h7FFF, 26'h0, "R3 max positive offset");
    step(1, 0, 1, 16'h0000, 26'h2A, "R5 jump with branch not taken");
    do_reset("R1 reset mid run");
    step(0, 0, 0, 16'h0000, 26'h0, "R2 after reset");
    @(posedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule